// File: doc/BRIEF.md
# Power-of-Two GPIO Input Debounce Filter

This block cleans up a bank of general-purpose input pins before their levels reach the edge-detection and input-status logic. Each pin's raw level first passes through a two-flop synchronizer. A per-pin filter cell then decides when the cleaned level is allowed to change. A single shared prescaler divides the system clock down to a one-cycle pulse once per millisecond. Every filter cell counts these pulses while its synchronized input disagrees with its current cleaned output.

Each pin is configured by a 9-bit control word. The top bit of the word turns filtering on. A 3-bit exponent picks a stable-time window of 2^exponent milliseconds, which gives windows from 1 ms to 128 ms. The cleaned output takes a new level only once the input has held that level for the whole window. Any return to the old level restarts the count. With filtering off, the cleaned output simply follows the synchronized input. Turning a requested time into an exponent is left to software, which rounds it to the nearest power of two. The millisecond divisor comes from a clock-frequency parameter.

Top module: `gpio_debounce`

## Requirements
- R1: The shared prescaler raises its tick for exactly one cycle out of every CLK_HZ/1000 cycles.
- R2: With the enable bit (bit 8 of a pin's control word) clear, `pin_clean` for that pin equals `pin_raw` delayed by three rising clock edges.
- R3: With filtering enabled, a new input level held steadily is passed to `pin_clean`. The change comes no earlier than (2^e − 1) ms plus two cycles after the raw change, and no later than 2^e ms plus three cycles, where e is the exponent.
- R4: With filtering enabled, a pulse shorter than (2^e − 1) ms never reaches `pin_clean`. Two such pulses separated by a return to the old level do not add up, because the return restarts the count.
- R5: The window exponent is bits 7:5 of the control word and the enable is bit 8. Bits 4:0 have no effect on filtering.
- R6: Exponent 0 selects a 1 ms window and exponent 7 selects a 128 ms window.
- R7: A change of a pin's enable bit or exponent restarts that pin's count. While filtering stays enabled, the cleaned output holds its value across the change.
- R8: During and right after reset, `pin_clean` equals the synchronized input, so no false edge follows reset release.
- R9: Each pin filters independently with its own window.
- R10: While a pin's filtering is enabled and its configuration is steady, its cleaned output changes only in the cycle after a prescaler tick, and only to the synchronized input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | N | Asynchronous raw pin levels |
| pin_ctrl | input | 9*N | Per-pin control words: bit 8 enable, bits 7:5 window exponent, bits 4:0 unused |
| pin_clean | output | N | Registered debounced pin levels |

## Verification
With filtering disabled, a raw change reaches `pin_clean` on the third rising edge: two synchronizer edges plus the output register. With filtering enabled, the change lands between (2^e − 1)·P + 2 and 2^e·P + 2 edges after the raw change, where P is the tick period in cycles. The exact point depends on the tick phase. Each check therefore samples at the negative edge at the safe end of that interval: the old level just before the earliest possible edge, and the new level just after the latest. Glitch and restart cases hold the output under watch over a span long enough that a missed restart would have let the output flip.

// File: rtl/gpio_debounce_pkg.sv
package gpio_debounce_pkg;
  localparam int CTRL_W   = 9;
  localparam int EN_BIT   = 8;
  localparam int EXP_LSB  = 5;
  localparam int EXP_W    = 3;
  localparam int MAX_EXP  = (1 << EXP_W) - 1;
  localparam int WCNT_W   = MAX_EXP + 1;

  typedef struct packed {
    logic             en;
    logic [EXP_W-1:0] exp;
  } flt_cfg_t;

  function automatic flt_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
    flt_cfg_t c;
    c.en  = w[EN_BIT];
    c.exp = w[EXP_LSB +: EXP_W];
    return c;
  endfunction
endpackage

// File: rtl/gpio_ms_prescaler.sv
module gpio_ms_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic ms_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      ms_tick <= 1'b0;
    end else begin
      ms_tick <= (div_cnt == LAST);
      if (div_cnt == LAST) div_cnt <= '0;
      else                 div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] d_sync
);
  logic [N-1:0] meta_q;

  // No reset: the stages carry the pin level straight through reset
  always_ff @(posedge clk) begin
    meta_q <= d_async;
    d_sync <= meta_q;
  end
endmodule

// File: rtl/gpio_flt_cell.sv
module gpio_flt_cell
  import gpio_debounce_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ms_tick,
  input  logic     lvl_sync,
  input  flt_cfg_t cfg,
  output logic     lvl_clean
);
  flt_cfg_t          cfg_q;
  logic [WCNT_W-1:0] ms_cnt;
  logic [WCNT_W-1:0] win_last;
  logic              cfg_moved;

  assign win_last  = (WCNT_W'(1) << cfg.exp) - WCNT_W'(1);
  assign cfg_moved = (cfg != cfg_q);

  always_ff @(posedge clk) begin
    cfg_q <= cfg;
    if (rst || !cfg.en) begin
      lvl_clean <= lvl_sync;
      ms_cnt    <= '0;
    end else if (cfg_moved || (lvl_sync == lvl_clean)) begin
      ms_cnt <= '0;
    end else if (ms_tick) begin
      if (ms_cnt >= win_last) begin
        lvl_clean <= lvl_sync;
        ms_cnt    <= '0;
      end else begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
  import gpio_debounce_pkg::*;
#(
  parameter int N      = 4,
  parameter int CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_raw,
  input  logic [N*CTRL_W-1:0] pin_ctrl,
  output logic [N-1:0]      pin_clean
);
  localparam int DIV = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  logic         ms_tick;
  logic [N-1:0] sync_q;
  logic [N*EXP_LSB-1:0] ctrl_unused;

  gpio_ms_prescaler #(.DIV(DIV)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .ms_tick (ms_tick)
  );

  gpio_in_sync #(.N(N)) u_sync (
    .clk     (clk),
    .d_async (pin_raw),
    .d_sync  (sync_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    flt_cfg_t cfg_i;
    assign cfg_i = decode_ctrl(pin_ctrl[i*CTRL_W +: CTRL_W]);
    assign ctrl_unused[i*EXP_LSB +: EXP_LSB] = pin_ctrl[i*CTRL_W +: EXP_LSB];

    gpio_flt_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .ms_tick   (ms_tick),
      .lvl_sync  (sync_q[i]),
      .cfg       (cfg_i),
      .lvl_clean (pin_clean[i])
    );
  end
endmodule

// File: rtl/gpio_debounce_chk.sv
module gpio_debounce_chk
  import gpio_debounce_pkg::*;
#(
  parameter int N   = 4,
  parameter int DIV = 1000
) (
  input logic                clk,
  input logic                rst,
  input logic                ms_tick,
  input logic [N-1:0]        sync_q,
  input logic [N*CTRL_W-1:0] pin_ctrl,
  input logic [N-1:0]        pin_clean
);
  localparam int GW = $clog2(DIV + 2) + 1;

  logic [1:0]    age;
  logic          seen_tick;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      age       <= '0;
      seen_tick <= 1'b0;
      gap       <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      if (ms_tick) begin
        seen_tick <= 1'b1;
        gap       <= '0;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1
  tick_period_chk: assert property (@(posedge clk) disable iff (rst)
    (ms_tick && seen_tick) |-> (gap == GW'(DIV - 1)));

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    (ms_tick && DIV > 1) |=> !ms_tick);

  for (genvar i = 0; i < N; i++) begin : g_chk
    logic       en_i;
    logic [3:0] cfg_i;
    assign en_i  = pin_ctrl[i*CTRL_W + EN_BIT];
    assign cfg_i = pin_ctrl[i*CTRL_W + EXP_LSB +: 4];

    // R2
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && $past(!en_i)) |-> (pin_clean[i] == $past(sync_q[i])));

    // R10
    change_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd2 && $past(en_i) && $past(cfg_i) == $past(cfg_i, 2) &&
       pin_clean[i] != $past(pin_clean[i]))
      |-> ($past(ms_tick) && pin_clean[i] == $past(sync_q[i])));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd2 && $past(en_i) && $past(cfg_i) != $past(cfg_i, 2))
      |-> $stable(pin_clean[i]));
  end
endmodule

bind gpio_debounce gpio_debounce_chk #(.N(N), .DIV(DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ms_tick   (ms_tick),
  .sync_q    (sync_q),
  .pin_ctrl  (pin_ctrl),
  .pin_clean (pin_clean)
);

// File: tb/gpio_debounce_bench.sv
module gpio_debounce_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int P          = 8;
  localparam int CLK_HZ     = P * 1000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   pin_raw = '0;
  logic [N*9-1:0] pin_ctrl = '0;
  logic [N-1:0]   pin_clean;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gpio_debounce #(.N(N), .CLK_HZ(CLK_HZ)) u_gpio_debounce (
    .clk       (clk),
    .rst       (rst),
    .pin_raw   (pin_raw),
    .pin_ctrl  (pin_ctrl),
    .pin_clean (pin_clean)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input int pin, input bit en, input int e, input int junk);
    pin_ctrl[pin*9 +: 9] = {en, 3'(e), 5'(junk)};
  endtask

  // R8: output loads the input level through reset, no edge after release
  task automatic t_reset();
    pin_raw = 4'b0101;
    for (int i = 0; i < N; i++) set_cfg(i, 1'b1, 2, 0);
    rst = 1'b1;
    edges(4);
    rst = 1'b0;
    @(negedge clk);
    check(pin_clean == 4'b0101, "R8 reset level", pin_clean, 4'b0101);
    edges(40);
    check(pin_clean == 4'b0101, "R8 no false edge", pin_clean, 4'b0101);
  endtask

  // R2 R5: disabled pin with exponent and junk bits set follows in 3 edges
  task automatic t_bypass();
    set_cfg(0, 1'b0, 7, 31);
    edges(2);
    pin_raw[0] = 1'b0;
    edges(2);
    check(pin_clean[0] == 1'b1, "R2 bypass before 3rd edge", pin_clean[0], 1);
    edges(1);
    check(pin_clean[0] == 1'b0, "R2 R5 bypass at 3rd edge", pin_clean[0], 0);
  endtask

  // R3 R6: window of 2^e ms on one pin, one level change
  task automatic t_window(input int pin, input int e, input string req);
    int win = 1 << e;
    int early = (win - 1) * P;
    bit old_v;
    if (early < 1) early = 1;
    old_v = pin_clean[pin];
    pin_raw[pin] = ~old_v;
    edges(early);
    check(pin_clean[pin] == old_v, {req, " held before window"}, pin_clean[pin], old_v);
    edges(win * P + 3 - early);
    check(pin_clean[pin] == ~old_v, {req, " passed after window"}, pin_clean[pin], !old_v);
  endtask

  // R4: two short pulses split by a brief return never reach the output
  task automatic t_glitch();
    bit old_v;
    bit moved = 1'b0;
    set_cfg(1, 1'b1, 2, 0);
    edges(4);
    old_v = pin_clean[1];
    pin_raw[1] = ~old_v; edges(3 * P - 1);
    pin_raw[1] = old_v;  edges(3);
    pin_raw[1] = ~old_v; edges(3 * P - 1);
    pin_raw[1] = old_v;
    for (int c = 0; c < 8 * P; c++) begin
      if (pin_clean[1] != old_v) moved = 1'b1;
      edges(1);
    end
    check(!moved, "R4 glitches rejected", moved, 0);
  endtask

  // R7: exponent change mid-count restarts the count, output held
  task automatic t_restart();
    bit old_v;
    set_cfg(2, 1'b1, 7, 0);
    edges(4);
    old_v = pin_clean[2];
    pin_raw[2] = ~old_v;
    edges(100 * P);
    check(pin_clean[2] == old_v, "R7 held under long window", pin_clean[2], old_v);
    set_cfg(2, 1'b1, 6, 0);
    edges(62 * P);
    check(pin_clean[2] == old_v, "R7 count restarted", pin_clean[2], old_v);
    edges(2 * P + 4);
    check(pin_clean[2] == ~old_v, "R7 passes after new window", pin_clean[2], !old_v);
  endtask

  // R9: two pins with different windows switch at their own times
  task automatic t_independent();
    bit a0, a3;
    set_cfg(0, 1'b1, 0, 0);
    set_cfg(3, 1'b1, 3, 0);
    edges(4);
    a0 = pin_clean[0];
    a3 = pin_clean[3];
    pin_raw[0] = ~a0;
    pin_raw[3] = ~a3;
    edges(P + 3);
    check(pin_clean[0] == ~a0, "R9 fast pin switched", pin_clean[0], !a0);
    check(pin_clean[3] == a3, "R9 slow pin held", pin_clean[3], a3);
    edges(7 * P);
    check(pin_clean[3] == ~a3, "R9 slow pin switched", pin_clean[3], !a3);
  endtask

  initial begin
    t_reset();
    t_bypass();
    set_cfg(0, 1'b1, 0, 21);
    edges(4);
    t_window(0, 0, "R6 R5 exponent 0");
    t_window(0, 0, "R3 exponent 0 back");
    set_cfg(1, 1'b1, 2, 0);
    edges(4);
    t_window(1, 2, "R3 exponent 2 rise");
    t_window(1, 2, "R3 exponent 2 fall");
    set_cfg(3, 1'b1, 7, 0);
    edges(4);
    t_window(3, 7, "R6 exponent 7");
    t_glitch();
    t_restart();
    t_independent();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule